// File: doc/BRIEF.md
# Test-and-Set Lock Register

This block is a single 32-bit word, reached through a simple slave port. A read is destructive. It hands back the word held before the access and, on the same clock edge, leaves the word holding one. A write stores the requester's data unchanged. Because the value returned and the overwrite happen on one edge, no other access can slip between them. This makes the word usable as a mutual-exclusion flag shared by several bus masters.

Software takes the lock by reading the word until it gets zero. It gives the lock back by writing zero. A router in front of the block passes in one request at a time, with the address already rebased so that the block sees local offsets starting at zero. Only offset zero is decoded. Other offsets read as zero and change nothing. All accesses are full words, and every request is answered one cycle after it is sampled.

Top module: `claim_register`

## Requirements
- R1: While reset is asserted and after it is released, the stored word is 0, `ready` is low and `rdData` is 0.
- R2: `ready` is high in exactly the cycle after each cycle in which `req` is sampled high, and low after every cycle in which `req` is low.
- R3: A read (`req`=1, `wrEn`=0) at local offset 0 presents the word stored before that read on `rdData` in its `ready` cycle.
- R4: After a read at offset 0, the stored word is 1, whatever it held before.
- R5: A write (`req`=1, `wrEn`=1) at offset 0 stores exactly `wrData`. The next read at offset 0 returns that value.
- R6: A read at any nonzero local offset returns 0. A read or write at a nonzero offset leaves the stored word unchanged.
- R7: After a write of 0, the first read at offset 0 returns 0 and each later read returns 1, until 0 is written again.
- R8: `rdData` is 0 in every cycle that does not follow a read at offset 0, including the `ready` cycle of a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, sampled each rising edge |
| wrEn | input | 1 | 1 = write, 0 = read (destructive) |
| addr | input | ADDR_W (8) | Local word offset; only 0 is decoded |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data, valid in the `ready` cycle |
| ready | output | 1 | Response strobe, one cycle after `req` |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit local offset and a set value of 1. With an 8-bit offset, random stimulus reaches both the single decoded offset and many undecoded ones, including the highest offset, 255. Random full-width write data reaches values whose upper bits differ from the set value, so a read that leaves anything other than exactly 1 behind shows up. Back-to-back requests with `req` held high exercise the case where the word is set on one edge and read again on the next.

// File: rtl/claim_pkg.sv
package claim_pkg;
  // Strobes passed from the control to the datapath for one sampled request
  typedef struct packed {
    logic wrLoad;  // store write data into the word
    logic rdSet;   // destructive read: force the set value
    logic rdOut;   // capture the old word onto the read bus
  } ctlStrobes_t;
endpackage

// File: rtl/claim_ctrl.sv
module claim_ctrl
  import claim_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LOCK_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes,
  output logic              ready
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(LOCK_OFFSET);

  logic addrHit;
  logic readyQ;

  assign addrHit = (addr == HIT_ADDR);

  always_comb begin
    strobes        = '0;
    strobes.wrLoad = req && wrEn && addrHit;
    strobes.rdSet  = req && !wrEn && addrHit;
    strobes.rdOut  = req && !wrEn && addrHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= req;
  end

  assign ready = readyQ;
endmodule

// File: rtl/claim_datapath.sv
module claim_datapath
  import claim_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int SET_VALUE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] wordQ,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [DATA_W-1:0] SET_WORD = DATA_W'(SET_VALUE);

  logic [DATA_W-1:0] rdQ;

  // Old value and overwrite share one edge: nothing can intervene
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      rdQ   <= '0;
    end else begin
      rdQ <= strobes.rdOut ? wordQ : '0;
      if (strobes.wrLoad)     wordQ <= wrData;
      else if (strobes.rdSet) wordQ <= SET_WORD;
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/claim_register.sv
module claim_register
  import claim_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int LOCK_OFFSET = 0,
  parameter int SET_VALUE   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ready
);
  ctlStrobes_t       strobes;
  logic [DATA_W-1:0] wordQ;

  claim_ctrl #(
    .ADDR_W(ADDR_W), .LOCK_OFFSET(LOCK_OFFSET)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr),
    .strobes(strobes), .ready(ready)
  );

  claim_datapath #(
    .DATA_W(DATA_W), .SET_VALUE(SET_VALUE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .wordQ(wordQ), .rdData(rdData)
  );
endmodule

// File: rtl/claim_register_chk.sv
module claim_register_chk #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int LOCK_OFFSET = 0,
  parameter int SET_VALUE   = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              ready,
  input logic [DATA_W-1:0] wordQ
);
  logic hitRd, hitWr, miss;
  assign hitRd = req && !wrEn && (addr == ADDR_W'(LOCK_OFFSET));
  assign hitWr = req && wrEn && (addr == ADDR_W'(LOCK_OFFSET));
  assign miss  = req && (addr != ADDR_W'(LOCK_OFFSET));

  AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> (wordQ == '0 && !ready && rdData == '0)); // R1
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) req |=> ready); // R2
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN) !req |=> !ready); // R2
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rstN) hitRd |=> rdData == $past(wordQ)); // R3
  AST_READ_SETS: assert property (@(posedge clk) disable iff (!rstN) hitRd |=> wordQ == DATA_W'(SET_VALUE)); // R4
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rstN) hitWr |=> wordQ == $past(wrData)); // R5
  AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rstN) miss |=> $stable(wordQ)); // R6
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rstN) !hitRd |=> rdData == '0); // R8
endmodule

bind claim_register claim_register_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOCK_OFFSET(LOCK_OFFSET), .SET_VALUE(SET_VALUE)
) chk_i (
  .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .ready(ready), .wordQ(wordQ)
);

// File: tb/claim_register_tb_top.sv
`timescale 1ns/1ps
module claim_register_tb_top;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              req = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              ready;

  int errors = 0;
  int checks = 0;
  logic [DATA_W-1:0] model = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  claim_register dut_i (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ready(ready)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected read data for one access, updating the reference word
  function automatic logic [DATA_W-1:0] expect_access(bit we, logic [ADDR_W-1:0] a,
                                                      logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r = '0;
    if (a == '0) begin
      if (we) model = d;
      else begin r = model; model = 32'd1; end
    end
    return r;
  endfunction

  // Drive at a falling edge, let the rising edge sample, check at next fall
  task automatic access(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string tag);
    logic [DATA_W-1:0] exp;
    req = 1'b1; wrEn = we; addr = a; wrData = d;
    exp = expect_access(we, a, d);
    @(posedge clk); @(negedge clk);
    check({tag, " R2 ready"}, {31'd0, ready}, 32'd1);
    check(tag, rdData, exp);
  endtask

  task automatic idle();
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R2 idle ready", {31'd0, ready}, 32'd0);
    check("R8 idle rdData", rdData, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd2417);
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, ready}, 32'd0);
    check("R1 rdData in reset", rdData, '0);
    rstN = 1'b1;
    idle();
    access(1'b0, 8'd0, '0, "R1 first read after reset");
    access(1'b0, 8'd0, '0, "R4 read after read gives 1");
    access(1'b1, 8'd0, 32'hDEAD_BEEF, "R8 write rdData zero");
    access(1'b0, 8'd0, '0, "R5 readback of write");
    access(1'b0, 8'd0, '0, "R4 set after full-width value");
    access(1'b1, 8'd0, '0, "R7 release");
    access(1'b0, 8'd0, '0, "R7 first claimer sees 0");
    access(1'b0, 8'd0, '0, "R7 second claimer sees 1");
    access(1'b0, 8'd0, '0, "R7 third claimer sees 1");
    access(1'b1, 8'd0, 32'h1234_5678, "R5 write");
    access(1'b1, 8'd255, 32'hFFFF_FFFF, "R6 write miss");
    access(1'b0, 8'd1, '0, "R6 read miss zero");
    access(1'b0, 8'd0, '0, "R6 word untouched by misses");
    idle();
    access(1'b0, 8'd0, '0, "R3 read after idle");
    for (int i = 0; i < 400; i++) begin
      bit we = ($urandom % 3) == 0;
      logic [ADDR_W-1:0] a = (($urandom % 10) < 7) ? '0 : ADDR_W'($urandom);
      logic [DATA_W-1:0] d = (($urandom % 4) == 0) ? '0 : $urandom;
      if (($urandom % 8) == 0) idle();
      access(we, a, d, "R3 random access");
    end
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule